// File: doc/BRIEF.md
# Parallel bus master

This block drives a general-purpose parallel bus toward an FPGA or CPLD. It takes one read or write request at a time from an internal valid/ready request port. For each request it runs one bus transaction on a 32-pin vector. The transaction has an optional address phase, then a data phase. Along with the pins it drives a bus clock, a frame marker, and read and write strobes. A ready input lets the far end stretch the data phase. Read data returns on a response port as a one-cycle pulse.

Static configuration inputs pick the options at run time:
- whether a bus clock is driven, and whether it runs freely or is gated;
- whether frame marking is used, and how many transactions make one frame;
- the data width and the address width;
- whether address and data share one phase or use separate phases;
- a pacing count that spaces transactions issued back to back.

The pacing count gives a fixed sampling period when reads are issued continuously. Configuration is expected to change only while the bus is idle.

Top module: `pbus_master`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_rd`, `bus_wr`, `bus_frame`, `pin_oe` and `rsp_valid` are all 0.
- R2: With `cfg_clk_en`=0, `bus_clk` stays 0 at all times.
- R3: With `cfg_clk_en`=1 and `cfg_clk_gate`=0, `bus_clk` changes level on every system clock cycle.
- R4: With `cfg_clk_en`=1 and `cfg_clk_gate`=1, `bus_clk` is 1 while idle and 0 in the first cycle of every phase. It returns to 1 for the remaining cycles of the phase, so a rising edge ends the first cycle of each phase.
- R5: In a write data phase, `bus_wr`=1 and `bus_rd`=0. The low DW data pins carry `req_wdata[DW-1:0]` with `pin_oe` set on those pins. `cfg_data_sel` encodes DW as 0→8, 1→16, 2 or 3→32. No data pin is enabled outside a write data phase, except for address pins in the split address phase.
- R6: A data phase holds its strobes, `pin_out` and `pin_oe` unchanged until `pin_rdy` is sampled 1 at a rising clock edge. That edge ends the phase.
- R7: A read data phase drives `bus_rd`=1. In the cycle after the completing edge, `rsp_valid` is 1 for exactly one cycle. `rsp_rdata` then equals `pin_in` as sampled at that edge, with pins at and above DW forced to 0.
- R8: Without split phases, the data phase drives the low AW address bits on pins starting at pin DW, with `pin_oe` set on them; address bits that would fall above pin 31 are dropped. `cfg_addr_sel` encodes AW as 0→0, 1→4, 2→12, 3→20.
- R9: With `cfg_split`=1, a two-cycle address phase comes first. It drives the low AW address bits on pins 0 upward, with `pin_oe` on them and both strobes 0. The data phase that follows drives no address pins.
- R10: `req_ready` is 1 only when idle with the pace count expired. After a transaction ends, exactly `cfg_div`+1 idle cycles pass before a waiting request is accepted.
- R11: With `cfg_frame_en`=1, `bus_frame` rises with the first transaction of a frame and stays high through gaps between back-to-back transactions. It falls after `cfg_frame_len`+1 transactions have completed (field value n-1 encodes n = 1..16).
- R12: When the bus is idle with the pace count expired and no request waiting, the frame ends and its count restarts. The next transaction then opens a new frame.
- R13: With `cfg_frame_en`=0, `bus_frame` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_en | input | 1 | Drive the bus clock |
| cfg_clk_gate | input | 1 | 1 = gated bus clock, 0 = free-running |
| cfg_frame_en | input | 1 | Enable frame marking |
| cfg_frame_len | input | 4 | Transactions per frame minus one |
| cfg_addr_sel | input | 2 | Address width select |
| cfg_data_sel | input | 2 | Data width select |
| cfg_split | input | 1 | Separate address and data phases |
| cfg_div | input | 8 | Idle cycles between transactions minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| bus_clk | output | 1 | Bus clock |
| bus_frame | output | 1 | Frame marker |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| pin_rdy | input | 1 | Far-end ready |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| pin_in | input | 32 | Pin input values |

## Verification
Random requests with random ready delays run under random combinations of width, split, clock, frame and pace settings. A per-cycle expected pin image catches misplaced address fields, leaked write data on reads and wrong enables. Back-to-back runs that are broken by deliberate idle gaps separate frame counting from frame restart, and they expose off-by-one pace gaps. Directed cases add the following:
- a 20-bit address shifted above an 8-bit data field, and dropped under a 32-bit field;
- single-transaction and sixteen-transaction frames;
- a disabled clock and a free-running clock, which each show a distinct clock pattern against the gated one.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int PIN_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} pbus_st_e;

  function automatic logic [5:0] data_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] addr_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd0;
      2'd1:    return 6'd4;
      2'd2:    return 6'd12;
      default: return 6'd20;
    endcase
  endfunction

  function automatic logic [PIN_W-1:0] low_mask(input logic [5:0] n);
    if (n >= 6'(PIN_W)) return '1;
    return (PIN_W'(1) << n) - PIN_W'(1);
  endfunction
endpackage

// File: rtl/pbus_pace.sv
module pbus_pace #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | (run & ~expired);

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (run) cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pbus_frame.sv
module pbus_frame #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic             clear,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             upd;

  assign active = act_q;
  assign upd    = start | done | clear;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (clear) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else begin
      if (start && !act_q) begin
        act_d = 1'b1;
        cnt_d = '0;
      end
      if (done) begin
        if (cnt_q == len) begin
          act_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/pbus_clkgen.sv
module pbus_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic gate,
  input  logic first,
  output logic bus_clk
);
  logic tog_q, tog_en;

  assign tog_en = en & ~gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= ~tog_q;
  end

  always_comb begin
    if (!en)       bus_clk = 1'b0;
    else if (gate) bus_clk = ~first;
    else           bus_clk = tog_q;
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_en,
  input  logic              cfg_clk_gate,
  input  logic              cfg_frame_en,
  input  logic [LEN_W-1:0]  cfg_frame_len,
  input  logic [1:0]        cfg_addr_sel,
  input  logic [1:0]        cfg_data_sel,
  input  logic              cfg_split,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PIN_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [PIN_W-1:0]  rsp_rdata,
  output logic              bus_clk,
  output logic              bus_frame,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              pin_rdy,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  input  logic [PIN_W-1:0]  pin_in
);
  pbus_st_e          state_q, state_d;
  logic              first_q, first_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PIN_W-1:0]  wdata_q;
  logic              rsp_valid_q;
  logic [PIN_W-1:0]  rsp_rdata_q;
  logic              pace_ok, accept, done, bus_idle, frame_act, active;
  logic [5:0]        dw, aw;
  logic [PIN_W-1:0]  dmask, amask, addr_ext, addr_hi, amask_hi;

  assign dw       = data_bits(cfg_data_sel);
  assign aw       = addr_bits(cfg_addr_sel);
  assign dmask    = low_mask(dw);
  assign amask    = low_mask(aw);
  assign addr_ext = PIN_W'(addr_q) & amask;
  assign addr_hi  = addr_ext << dw;
  assign amask_hi = amask << dw;

  assign active    = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE) & pace_ok;
  assign accept    = req_ready & req_valid;
  assign done      = (state_q == ST_DATA) & pin_rdy;
  assign bus_idle  = req_ready & ~req_valid;

  pbus_pace #(.DIV_W(DIV_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .load(done), .load_val(cfg_div),
    .run(state_q == ST_IDLE), .expired(pace_ok)
  );

  pbus_frame #(.LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(accept), .done(done),
    .clear(bus_idle), .len(cfg_frame_len), .active(frame_act)
  );

  pbus_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(cfg_clk_en), .gate(cfg_clk_gate),
    .first(active & first_q), .bus_clk(bus_clk)
  );

  // phase sequencer: next state
  always_comb begin
    state_d = state_q;
    first_d = first_q;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = cfg_split ? ST_ADDR : ST_DATA;
        first_d = 1'b1;
      end
      ST_ADDR: if (first_q) begin
        first_d = 1'b0;
      end else begin
        state_d = ST_DATA;
        first_d = 1'b1;
      end
      default: begin
        first_d = 1'b0;
        if (pin_rdy) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= done & ~wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rsp_rdata_q <= '0;
    else if (done && !wr_q)  rsp_rdata_q <= pin_in & dmask;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign bus_frame = cfg_frame_en & frame_act;
  assign bus_rd    = (state_q == ST_DATA) & ~wr_q;
  assign bus_wr    = (state_q == ST_DATA) &  wr_q;

  // pin image per phase
  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    case (state_q)
      ST_ADDR: begin
        pin_out = addr_ext;
        pin_oe  = amask;
      end
      ST_DATA: begin
        if (!cfg_split) begin
          pin_out = addr_hi;
          pin_oe  = amask_hi;
        end
        if (wr_q) begin
          pin_out = pin_out | (wdata_q & dmask);
          pin_oe  = pin_oe | dmask;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_clk_en,
  input logic        cfg_clk_gate,
  input logic        cfg_frame_en,
  input logic        req_ready,
  input logic        bus_clk,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_frame,
  input logic        pin_rdy,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic        rsp_valid
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && !pin_rdy |=>
      $stable(pin_out) && $stable(pin_oe) && $stable(bus_rd) && $stable(bus_wr));

  a_r7_rsp_src: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> past_ok && $past(bus_rd && pin_rdy));

  a_r2_noclk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_en |-> !bus_clk);

  a_r4_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_en && cfg_clk_gate && req_ready |-> bus_clk);

  a_r3_free_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && cfg_clk_en && !cfg_clk_gate && $past(cfg_clk_en && !cfg_clk_gate)
      |-> bus_clk != $past(bus_clk));

  a_r13_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_frame_en |-> !bus_frame);

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_rd && !bus_wr && pin_oe == 32'd0);
endmodule

bind pbus_master pbus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clk_en(cfg_clk_en), .cfg_clk_gate(cfg_clk_gate),
  .cfg_frame_en(cfg_frame_en), .req_ready(req_ready), .bus_clk(bus_clk),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_frame(bus_frame), .pin_rdy(pin_rdy),
  .pin_out(pin_out), .pin_oe(pin_oe), .rsp_valid(rsp_valid)
);

// File: tb/pbus_master_bench.sv
`timescale 1ns/1ps
module pbus_master_bench;
  logic        clk, rst_n;
  logic        c_clk_en, c_gate, c_fen, c_split;
  logic [3:0]  c_flen;
  logic [1:0]  c_asel, c_dsel;
  logic [7:0]  c_div;
  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_clk, bus_frame, bus_rd, bus_wr, pin_rdy;
  logic [31:0] pin_out, pin_oe, pin_in;

  int n_chk = 0;
  int n_bad = 0;
  bit ef_act = 0;
  int ef_cnt = 0;

  pbus_master u_pbus_master (
    .clk(clk), .rst_n(rst_n), .cfg_clk_en(c_clk_en), .cfg_clk_gate(c_gate),
    .cfg_frame_en(c_fen), .cfg_frame_len(c_flen), .cfg_addr_sel(c_asel),
    .cfg_data_sel(c_dsel), .cfg_split(c_split), .cfg_div(c_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_clk(bus_clk), .bus_frame(bus_frame),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .pin_rdy(pin_rdy), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_in(pin_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int f_dw(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic int f_aw(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 4;
      2'd2: return 12;
      default: return 20;
    endcase
  endfunction

  function automatic logic [31:0] f_mask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] f_shift(input logic [31:0] v, input int n);
    logic [63:0] w;
    w = {32'd0, v} << n;
    return w[31:0];
  endfunction

  task automatic chk_clk(input bit first_cyc, input bit act);
    if (!c_clk_en) check("R2 clock off", {31'd0, bus_clk}, 32'd0);
    else if (c_gate) check("R4 gated clock", {31'd0, bus_clk}, {31'd0, !(act && first_cyc)});
  endtask

  task automatic chk_frame(input string tag);
    check(tag, {31'd0, bus_frame}, {31'd0, c_fen & ef_act});
  endtask

  // one transaction, entered just after a negedge; returns after completion negedge
  task automatic run_txn(input bit wr, input logic [19:0] a, input logic [31:0] d,
                         input int waits, input logic [31:0] rdv, input bit pace_chk);
    int w;
    int dw;
    int aw;
    logic [31:0] e_out, e_oe;
    dw = f_dw(c_dsel);
    aw = f_aw(c_asel);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    w = 1;
    while (!req_ready && w < 1000) begin
      @(negedge clk);
      w++;
    end
    if (pace_chk) check("R10 pace gap", w, c_div + 8'd1);
    if (!ef_act) begin ef_act = 1; ef_cnt = 0; end
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    if (c_split) begin
      for (int k = 0; k < 2; k++) begin
        check("R9 addr phase strobes", {30'd0, bus_rd, bus_wr}, 32'd0);
        check("R9 addr phase pins", pin_out, {12'd0, a} & f_mask(aw));
        check("R9 addr phase oe", pin_oe, f_mask(aw));
        chk_clk(k == 0, 1'b1);
        chk_frame("R11 frame in addr phase");
        @(negedge clk);
      end
    end
    e_out = c_split ? 32'd0 : f_shift({12'd0, a} & f_mask(aw), dw);
    e_oe  = c_split ? 32'd0 : f_shift(f_mask(aw), dw);
    if (wr) begin
      e_out = e_out | (d & f_mask(dw));
      e_oe  = e_oe | f_mask(dw);
    end
    for (int k = 0; k <= waits; k++) begin
      check(wr ? "R5 write strobe" : "R7 read strobe", {30'd0, bus_rd, bus_wr}, wr ? 32'd1 : 32'd2);
      check(k == 0 ? "R8 data pins" : "R6 held pins", pin_out, e_out);
      check(k == 0 ? "R5 data oe" : "R6 held oe", pin_oe, e_oe);
      chk_clk(k == 0, 1'b1);
      chk_frame("R11 frame in data phase");
      if (k == waits) begin pin_rdy = 1'b1; pin_in = rdv; end
      @(negedge clk);
    end
    pin_rdy = 1'b0;
    pin_in = $urandom;
    check("R6 phase ends on ready", {30'd0, bus_rd, bus_wr}, 32'd0);
    check("R7 response pulse", {31'd0, rsp_valid}, {31'd0, !wr});
    if (!wr) check("R7 read data", rsp_rdata, rdv & f_mask(dw));
    ef_cnt++;
    if (ef_cnt == int'(c_flen) + 1) begin ef_act = 0; ef_cnt = 0; end
    chk_frame("R11 frame after completion");
  endtask

  task automatic go_idle();
    req_valid = 1'b0;
    @(negedge clk);
    check("R7 pulse lasts one cycle", {31'd0, rsp_valid}, 32'd0);
    repeat (int'(c_div) + 2) @(negedge clk);
    ef_act = 0; ef_cnt = 0;
    check("R12 frame cleared on idle", {31'd0, bus_frame}, 32'd0);
    check("R10 ready when idle", {31'd0, req_ready}, 32'd1);
    check("R5 no oe when idle", pin_oe, 32'd0);
    chk_clk(1'b0, 1'b0);
  endtask

  task automatic rand_cfg();
    c_clk_en = 1'($urandom);
    c_gate   = 1'($urandom);
    c_fen    = 1'($urandom);
    c_split  = 1'($urandom);
    c_flen   = 4'($urandom % 4);
    c_asel   = 2'($urandom);
    c_dsel   = 2'($urandom);
    c_div    = 8'($urandom % 5);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    c_clk_en = 1; c_gate = 1; c_fen = 1; c_split = 0;
    c_flen = 0; c_asel = 0; c_dsel = 0; c_div = 0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    pin_rdy = 0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1 strobes after reset", {29'd0, bus_rd, bus_wr, bus_frame}, 32'd0);
    check("R1 oe after reset", pin_oe, 32'd0);
    check("R1 rsp after reset", {31'd0, rsp_valid}, 32'd0);
    check("R4 gated clock idles high", {31'd0, bus_clk}, 32'd1);

    // R8: 20-bit address above 8-bit data, read
    c_asel = 3; c_dsel = 0; c_split = 0; c_fen = 1; c_flen = 0;
    run_txn(1'b0, 20'hABCDE, 32'h0, 2, 32'h1234_5678, 1'b0);
    go_idle();
    // R8: 32-bit data drops address
    c_dsel = 2;
    run_txn(1'b1, 20'hFFFFF, 32'hDEAD_BEEF, 0, 32'h0, 1'b0);
    go_idle();
    // R9: split write with 12-bit address, gated clock
    c_split = 1; c_asel = 2; c_dsel = 1;
    run_txn(1'b1, 20'h12345, 32'hCAFE_F00D, 1, 32'h0, 1'b0);
    go_idle();
    // R11: sixteen-transaction frame, back to back, pace 2
    c_split = 0; c_flen = 4'd15; c_div = 2; c_asel = 1;
    for (int i = 0; i < 17; i++)
      run_txn(1'(i), 20'(i), 32'(i * 3), i % 2, 32'(i * 7), i != 0);
    check("R11 new frame open after 16", {31'd0, bus_frame}, 32'd1);
    go_idle();
    // R12: idle mid-frame restarts count
    c_flen = 4'd2;
    run_txn(1'b1, 20'h1, 32'h1, 0, 32'h0, 1'b0);
    go_idle();
    run_txn(1'b1, 20'h2, 32'h2, 0, 32'h0, 1'b0);
    run_txn(1'b1, 20'h3, 32'h3, 0, 32'h0, 1'b1);
    check("R12 frame still open after restart", {31'd0, bus_frame}, 32'd1);
    go_idle();
    // R13 and R2: frame and clock disabled
    c_fen = 0; c_clk_en = 0;
    run_txn(1'b0, 20'h5, 32'h0, 1, 32'hA5A5_A5A5, 1'b0);
    go_idle();
    // R3: free-running clock
    c_clk_en = 1; c_gate = 0;
    @(negedge clk);
    begin
      logic prev;
      prev = bus_clk;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        check("R3 free clock toggles", {31'd0, bus_clk}, {31'd0, ~prev});
        prev = bus_clk;
      end
    end
    // random batches
    for (int b = 0; b < 40; b++) begin
      int n;
      rand_cfg();
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++)
        run_txn(1'($urandom), 20'($urandom), $urandom, int'($urandom % 4), $urandom, i != 0);
      go_idle();
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule